// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider Control

This block is the digital control for a synthesizer feedback divider. The divider is built from a dual-modulus prescaler, which divides the oscillator by 16 or 17, and a pair of counters. The oscillator-rate clock drives the block. The prescaler, which sits outside the block, returns one strobe at the end of each of its cycles. The block tells the prescaler which modulus to use for the cycle in progress. It emits a one-clock pulse toward the phase comparator each time N oscillator cycles have passed.

Software supplies the 15-bit ratio in two writes: an upper half of 7 bits and a lower half of 8 bits. The ratio is committed once both halves have been written, in either order or in the same cycle. The committed ratio waits in a pending register and becomes active only when the current output period ends. The low four bits of the ratio set the swallow count A. The upper eleven bits set the main count M. The prescaler runs A cycles at 17 and M−A cycles at 16, so one period is 16·M + A = N. For the swallow count to fit inside the main count, M must be at least 15, which gives a smallest ratio of 240. A committed ratio below 240 is raised to 240 and a flag is set.

Top module: `swallow_divider`

## Requirements
- R1: While reset is held, `divOut`, `modHigh` and `lowClamp` are 0. After reset, the active ratio is 240.
- R2: For an active ratio N in 240..32767, consecutive `divOut` pulses are exactly N clock cycles apart.
- R3: `divOut` is high for exactly one clock cycle per period, and only in the cycle after a prescaler strobe `pscPulse`.
- R4: Within a period, `modHigh` is 1 for the first A = N[3:0] prescaler cycles and 0 for the remaining M−A cycles, where M = N[14:4]. It changes only after a `pscPulse`. A ratio with A = 15 still gives a period of exactly N.
- R5: A commit happens on the clock edge that completes writes to both halves since the previous commit. The halves may be written upper-then-lower, lower-then-upper, or in one cycle. The committed ratio is {`wrHiData`, `wrLoData`}, using the most recent value of each half.
- R6: A write to only one half does not change the period and does not change `lowClamp`.
- R7: A committed ratio becomes active only at the next period end. The period in progress keeps its old length.
- R8: A committed ratio below 240 becomes 240 and sets `lowClamp` to 1. A commit of 240 or more clears `lowClamp`. `lowClamp` changes only on a commit.
- R9: The largest ratio, 32767, gives a period of 32767 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrHiEn | input | 1 | Write strobe for the upper ratio half |
| wrHiData | input | 7 | Ratio bits 14:8 |
| wrLoEn | input | 1 | Write strobe for the lower ratio half |
| wrLoData | input | 8 | Ratio bits 7:0 |
| pscPulse | input | 1 | Prescaler end-of-cycle strobe |
| modHigh | output | 1 | Modulus control: 1 selects divide-by-17 |
| divOut | output | 1 | One-cycle pulse at each period end |
| lowClamp | output | 1 | Last commit was raised to the minimum ratio |

## Verification
The bench builds the block with its default parameters: a 15-bit ratio split as 8+7, and a prescaler with a 4-bit modulus step (16/17). With these values the bench reaches the 240 minimum, the ratio just below it, a swallow count of 15, and the 32767 maximum, each within a few periods. A behavioural prescaler samples `modHigh` at the end of each of its cycles. Each measured pulse interval therefore depends on the modulus sequence being correct, not only on the counters. Commits are made in the middle of a period, so the bench can see the old period finish before the new length takes over.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  // strobes issued by the control toward the counter datapath
  typedef struct packed {
    logic reload;  // current period ends this cycle: restart counters
    logic swapIn;  // take the pending ratio at this restart
  } swdivStrb_t;
endpackage

// File: rtl/swdiv_ctrl.sv
module swdiv_ctrl
  import swdiv_pkg::*;
#(
  parameter int RATIO_W = 15,
  parameter int LO_W    = 8,
  parameter int PSC_LOG = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrHiEn,
  input  logic [RATIO_W-LO_W-1:0] wrHiData,
  input  logic                wrLoEn,
  input  logic [LO_W-1:0]     wrLoData,
  input  logic                periodEnd,
  output swdivStrb_t          strb,
  output logic [RATIO_W-1:0]  pendRatio,
  output logic                lowClamp
);
  localparam int HI_W      = RATIO_W - LO_W;
  localparam int MIN_RATIO = (1 << PSC_LOG) * ((1 << PSC_LOG) - 1);

  logic [HI_W-1:0]    hiStage;
  logic [LO_W-1:0]    loStage;
  logic               hiSeen, loSeen, pendValid;
  logic [HI_W-1:0]    hiNext;
  logic [LO_W-1:0]    loNext;
  logic [RATIO_W-1:0] rawRatio, safeRatio;
  logic               tooLow, commitNow;

  always_comb begin
    hiNext    = wrHiEn ? wrHiData : hiStage;
    loNext    = wrLoEn ? wrLoData : loStage;
    rawRatio  = {hiNext, loNext};
    tooLow    = rawRatio < RATIO_W'(MIN_RATIO);
    safeRatio = tooLow ? RATIO_W'(MIN_RATIO) : rawRatio;
    commitNow = (wrHiEn | wrLoEn) & (hiSeen | wrHiEn) & (loSeen | wrLoEn);
    strb.reload = periodEnd;
    strb.swapIn = periodEnd & pendValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiStage   <= '0;
      loStage   <= '0;
      hiSeen    <= 1'b0;
      loSeen    <= 1'b0;
      pendValid <= 1'b0;
      pendRatio <= RATIO_W'(MIN_RATIO);
      lowClamp  <= 1'b0;
    end else begin
      hiStage <= hiNext;
      loStage <= loNext;
      if (commitNow) begin
        hiSeen    <= 1'b0;
        loSeen    <= 1'b0;
        pendRatio <= safeRatio;
        lowClamp  <= tooLow;
        pendValid <= 1'b1;
      end else begin
        if (wrHiEn) hiSeen <= 1'b1;
        if (wrLoEn) loSeen <= 1'b1;
        if (strb.swapIn) pendValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swdiv_path.sv
module swdiv_path
  import swdiv_pkg::*;
#(
  parameter int RATIO_W = 15,
  parameter int PSC_LOG = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pscPulse,
  input  swdivStrb_t         strb,
  input  logic [RATIO_W-1:0] pendRatio,
  output logic               modHigh,
  output logic               divOut,
  output logic               periodEnd,
  output logic [RATIO_W-1:0] activeRatio
);
  localparam int M_W       = RATIO_W - PSC_LOG;
  localparam int MIN_RATIO = (1 << PSC_LOG) * ((1 << PSC_LOG) - 1);
  localparam logic [RATIO_W-1:0] MIN_VEC = RATIO_W'(MIN_RATIO);

  logic [M_W-1:0]     mainLeft;
  logic [PSC_LOG-1:0] swallowLeft;
  logic [RATIO_W-1:0] srcRatio;

  always_comb begin
    periodEnd = pscPulse & (mainLeft == '0);
    modHigh   = swallowLeft != '0;
    srcRatio  = strb.swapIn ? pendRatio : activeRatio;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeRatio <= MIN_VEC;
      mainLeft    <= MIN_VEC[RATIO_W-1:PSC_LOG] - M_W'(1);
      swallowLeft <= MIN_VEC[PSC_LOG-1:0];
      divOut      <= 1'b0;
    end else begin
      divOut <= periodEnd;
      if (strb.reload) begin
        mainLeft    <= srcRatio[RATIO_W-1:PSC_LOG] - M_W'(1);
        swallowLeft <= srcRatio[PSC_LOG-1:0];
        if (strb.swapIn) activeRatio <= pendRatio;
      end else if (pscPulse) begin
        mainLeft <= mainLeft - M_W'(1);
        if (swallowLeft != '0) swallowLeft <= swallowLeft - PSC_LOG'(1);
      end
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int RATIO_W = 15,
  parameter int LO_W    = 8,
  parameter int PSC_LOG = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrHiEn,
  input  logic [RATIO_W-LO_W-1:0]  wrHiData,
  input  logic                     wrLoEn,
  input  logic [LO_W-1:0]          wrLoData,
  input  logic                     pscPulse,
  output logic                     modHigh,
  output logic                     divOut,
  output logic                     lowClamp
);
  swdivStrb_t         strb;
  logic               periodEnd;
  logic [RATIO_W-1:0] pendRatio;
  logic [RATIO_W-1:0] activeRatio;

  swdiv_ctrl #(.RATIO_W(RATIO_W), .LO_W(LO_W), .PSC_LOG(PSC_LOG)) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrHiEn(wrHiEn), .wrHiData(wrHiData),
    .wrLoEn(wrLoEn), .wrLoData(wrLoData),
    .periodEnd(periodEnd), .strb(strb),
    .pendRatio(pendRatio), .lowClamp(lowClamp)
  );

  swdiv_path #(.RATIO_W(RATIO_W), .PSC_LOG(PSC_LOG)) uPath (
    .clk(clk), .rstN(rstN), .pscPulse(pscPulse),
    .strb(strb), .pendRatio(pendRatio),
    .modHigh(modHigh), .divOut(divOut),
    .periodEnd(periodEnd), .activeRatio(activeRatio)
  );
endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk #(
  parameter int RATIO_W = 15
) (
  input logic               clk,
  input logic               rstN,
  input logic               pscPulse,
  input logic               modHigh,
  input logic               divOut,
  input logic               lowClamp,
  input logic               wrHiEn,
  input logic               wrLoEn,
  input logic               periodEnd,
  input logic [RATIO_W-1:0] activeRatio
);
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    divOut |=> !divOut);
  // R3
  pulse_follows_psc_chk: assert property (@(posedge clk) disable iff (!rstN)
    divOut |-> $past(pscPulse));
  // R4
  modulus_steps_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modHigh) |-> $past(pscPulse));
  // R7
  ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeRatio) |-> $past(periodEnd));
  // R8
  clamp_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lowClamp) |-> $past(wrHiEn || wrLoEn));
endmodule

bind swallow_divider swdiv_chk #(.RATIO_W(RATIO_W)) uChk (
  .clk(clk), .rstN(rstN), .pscPulse(pscPulse), .modHigh(modHigh),
  .divOut(divOut), .lowClamp(lowClamp), .wrHiEn(wrHiEn), .wrLoEn(wrLoEn),
  .periodEnd(periodEnd), .activeRatio(activeRatio)
);

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrHiEn = 1'b0, wrLoEn = 1'b0;
  logic [6:0] wrHiData = '0;
  logic [7:0] wrLoData = '0;
  logic       pscPulse, modHigh, divOut, lowClamp;
  logic [4:0] pcnt;

  int total = 0, bad = 0;
  int expQ[$];
  string tagQ[$];
  int curEff = 240;
  bit curFlag = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  swallow_divider dut (
    .clk(clk), .rstN(rstN), .wrHiEn(wrHiEn), .wrHiData(wrHiData),
    .wrLoEn(wrLoEn), .wrLoData(wrLoData), .pscPulse(pscPulse),
    .modHigh(modHigh), .divOut(divOut), .lowClamp(lowClamp)
  );

  // behavioural 16/17 prescaler: modulus sampled at the end of its cycle
  assign pscPulse = (pcnt == 5'd15 && !modHigh) || (pcnt == 5'd16);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcnt <= '0;
    else if (pscPulse) pcnt <= '0;
    else pcnt <= pcnt + 5'd1;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures each interval between output pulses
  int cnt = 0;
  bit refSeen = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      cnt++;
      if (divOut) begin
        if (refSeen) begin
          if (expQ.size() == 0) check("R3 unexpected pulse", cnt, -1);
          else check(tagQ.pop_front(), cnt, expQ.pop_front());
        end
        refSeen = 1'b1;
        cnt = 0;
      end
    end
  end

  task automatic waitPulse();
    @(negedge clk);
    while (!divOut) @(negedge clk);
  endtask

  // mode 0: lo then hi, 1: hi then lo, 2: same cycle, 3: lo only, 4: hi only
  task automatic apply(input int r, input int mode, input int n, input string tag);
    logic [14:0] rv = 15'(r);
    bit commits = (mode != 3);
    waitPulse();
    case (mode)
      0: begin
        wrLoEn = 1; wrLoData = rv[7:0]; @(negedge clk); wrLoEn = 0;
        wrHiEn = 1; wrHiData = rv[14:8]; @(negedge clk); wrHiEn = 0;
      end
      1: begin
        wrHiEn = 1; wrHiData = rv[14:8]; @(negedge clk); wrHiEn = 0;
        wrLoEn = 1; wrLoData = rv[7:0]; @(negedge clk); wrLoEn = 0;
      end
      2: begin
        wrHiEn = 1; wrHiData = rv[14:8]; wrLoEn = 1; wrLoData = rv[7:0];
        @(negedge clk); wrHiEn = 0; wrLoEn = 0;
      end
      3: begin wrLoEn = 1; wrLoData = rv[7:0]; @(negedge clk); wrLoEn = 0; end
      default: begin wrHiEn = 1; wrHiData = rv[14:8]; @(negedge clk); wrHiEn = 0; end
    endcase
    // period in progress keeps its length (R7)
    expQ.push_back(curEff); tagQ.push_back({tag, " R7 old period"});
    if (commits) begin
      curEff = (r < 240) ? 240 : r;
      curFlag = (r < 240);
    end
    check({tag, " lowClamp"}, int'(lowClamp), int'(curFlag));
    for (int i = 0; i < n; i++) begin
      expQ.push_back(curEff); tagQ.push_back(tag);
    end
    repeat (n) waitPulse();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 divOut in reset", int'(divOut), 0);
    check("R1 modHigh in reset", int'(modHigh), 0);
    check("R1 lowClamp in reset", int'(lowClamp), 0);
    rstN = 1'b1;
    // first measured period uses the reset ratio 240 (R1)
    apply(1000, 0, 2, "R1 R2 lo-hi");
    apply(255, 1, 2, "R4 swallow15 hi-lo");
    apply(241, 2, 2, "R5 R2 same-cycle");
    apply(5000, 3, 1, "R6 lo-only");
    apply(5000, 4, 2, "R5 hi completes");
    apply(100, 0, 2, "R8 clamp100");
    apply(239, 1, 1, "R8 clamp239");
    apply(240, 2, 2, "R8 min240");
    apply(32767, 0, 1, "R9 max");
    apply(271, 2, 1, "R4 R2 271");
    waitPulse();
    @(negedge clk);
    check("R2 queue drained", expQ.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule